// File: doc/BRIEF.md
# Programmable Memory-Map Address Decoder

This block sits on a 16-bit microcontroller bus and turns the upper address bits into two chip selects. One select covers a 1K-byte window for on-chip registers. The other covers an 8K-byte window for nonvolatile program memory. The base of each window comes from a field of its own configuration byte, so software can move either window anywhere on a matching boundary. The selects are combinational, so they follow the address bus with no clock delay.

The same configuration bytes set two other functions. One bit chooses whether the external reset pin is active high or active low. The block always presents the internal reset as active high. A second bit switches port B between ordinary general-purpose I/O and a mode that drives out the low address byte. In that mode the low byte is captured from the multiplexed bus when the address strobe falls. The write path for the configuration bytes and the nonvolatile cells that hold them lie outside this block.

Top module: `mmap_decoder`

## Requirements
- R1: `reg_sel_o` is 1 exactly when `addr_i[15:10]` equals `regmap_cfg_i[5:0]` and `regmap_cfg_i[7:6]` is binary 10. This holds combinationally in the same cycle. The configuration value after power-up is 0x81.
- R2: When `regmap_cfg_i[7:6]` is any value other than binary 10, the register map is invalid and `reg_sel_o` stays 0 for every address.
- R3: `mem_sel_o` is 1 exactly when `addr_i[15:13]` equals `memmap_cfg_i[2:0]` and `reg_sel_o` is 0. This is combinational. The configuration value after power-up is 0x07.
- R4: When both windows match one address, the register window wins. `reg_sel_o` is then 1 and `mem_sel_o` is 0, and the two selects are never 1 together.
- R5: `core_rst_o` is always active high. It equals `rst_pin_i` when `memmap_cfg_i[3]` is 1, and it equals the inverse of `rst_pin_i` when that bit is 0.
- R6: When `memmap_cfg_i[5]` is 0, port B passes through the ordinary I/O values: `pb_out_o` equals `gpio_out_i` and `pb_oe_o` equals `gpio_oe_i`.
- R7: When `memmap_cfg_i[5]` is 1, `pb_oe_o` is all ones and `pb_out_o` drives the latched low address byte.
- R8: At a rising `clk` edge where `as_i` was 1 at the previous edge and is now 0, the block captures `addr_i[7:0]`. The captured byte appears on `pb_out_o` (in latched mode) after that edge. It holds until the next such falling strobe, whatever the address does in between.
- R9: While `rst_n` is low, the latched low byte is cleared to 0x00.
- R10: `memmap_cfg_i` bits 7, 6 and 4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for the address latch |
| addr_i | input | 16 | Address bus |
| as_i | input | 1 | Address strobe; a falling strobe captures the low byte |
| rst_pin_i | input | 1 | Raw external reset pin |
| regmap_cfg_i | input | 8 | Register-window configuration byte |
| memmap_cfg_i | input | 8 | Memory-window, reset-polarity and port-B-mode configuration byte |
| gpio_out_i | input | 8 | Port B data from the ordinary I/O logic |
| gpio_oe_i | input | 8 | Port B drive enables from the ordinary I/O logic |
| reg_sel_o | output | 1 | Register-window select |
| mem_sel_o | output | 1 | Program-memory-window select |
| core_rst_o | output | 1 | Internal reset, active high |
| pb_out_o | output | 8 | Port B output data |
| pb_oe_o | output | 8 | Port B drive enables |

## Verification
The two selects, the normalized reset and the port B mux in I/O mode depend on no clock. The bench therefore changes inputs just after a falling clock edge and samples one nanosecond later, within the same cycle. The latched byte passes through one register. Its value is due just after the first rising edge at which a falling strobe is seen. The bench drops the strobe at a falling edge and checks `pb_out_o` at the following falling edge. It then moves the address and checks again over later cycles to confirm the byte holds.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
    localparam int BYTE_W       = 8;
    localparam int CFG_W        = 8;
    // register-map byte: valid signature field in the top two bits
    localparam int RM_SIG_HI    = 7;
    localparam int RM_SIG_LO    = 6;
    localparam logic [1:0] RM_SIG_OK = 2'b10;
    // memory-map byte: control bits
    localparam int MM_LAM_BIT   = 5;
    localparam int MM_POL_BIT   = 3;

    typedef struct packed {
        logic              as_prev;
        logic [BYTE_W-1:0] lat;
    } lat_state_t;
endpackage

// File: rtl/mmap_win_cmp.sv
module mmap_win_cmp #(
    parameter  int ADDR_W   = 16,
    parameter  int WIN_BITS = 10,
    localparam int TAG_W    = ADDR_W - WIN_BITS
) (
    input  logic [TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0] base_i,
    input  logic             en_i,
    output logic             hit_o
);
    always_comb begin
        hit_o = en_i && (tag_i == base_i);
    end
endmodule

// File: rtl/mmap_lo_latch.sv
module mmap_lo_latch
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_i,
    input  logic [BYTE_W-1:0] lo_i,
    output logic [BYTE_W-1:0] lat_o
);
    lat_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.as_prev = as_i;
        if (st_q.as_prev && !as_i) begin
            st_d.lat = lo_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o = st_q.lat;
endmodule

// File: rtl/mmap_portb_mux.sv
module mmap_portb_mux
    import mmap_pkg::*;
(
    input  logic              lam_i,
    input  logic [BYTE_W-1:0] lat_i,
    input  logic [BYTE_W-1:0] gpio_out_i,
    input  logic [BYTE_W-1:0] gpio_oe_i,
    output logic [BYTE_W-1:0] pb_out_o,
    output logic [BYTE_W-1:0] pb_oe_o
);
    always_comb begin
        if (lam_i) begin
            pb_out_o = lat_i;
            pb_oe_o  = '1;
        end else begin
            pb_out_o = gpio_out_i;
            pb_oe_o  = gpio_oe_i;
        end
    end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int REG_WIN_BITS = 10,
    parameter int MEM_WIN_BITS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              as_i,
    input  logic              rst_pin_i,
    input  logic [CFG_W-1:0]  regmap_cfg_i,
    input  logic [CFG_W-1:0]  memmap_cfg_i,
    input  logic [BYTE_W-1:0] gpio_out_i,
    input  logic [BYTE_W-1:0] gpio_oe_i,
    output logic              reg_sel_o,
    output logic              mem_sel_o,
    output logic              core_rst_o,
    output logic [BYTE_W-1:0] pb_out_o,
    output logic [BYTE_W-1:0] pb_oe_o
);
    localparam int REG_TAG_W = ADDR_W - REG_WIN_BITS;
    localparam int MEM_TAG_W = ADDR_W - MEM_WIN_BITS;

    logic              rm_valid;
    logic              reg_hit;
    logic              mem_hit;
    logic [BYTE_W-1:0] lat_byte;
    logic              unused_cfg;

    assign rm_valid = (regmap_cfg_i[RM_SIG_HI:RM_SIG_LO] == RM_SIG_OK);

    mmap_win_cmp #(.ADDR_W(ADDR_W), .WIN_BITS(REG_WIN_BITS)) u_reg_cmp (
        .tag_i  (addr_i[ADDR_W-1 -: REG_TAG_W]),
        .base_i (regmap_cfg_i[REG_TAG_W-1:0]),
        .en_i   (rm_valid),
        .hit_o  (reg_hit)
    );

    mmap_win_cmp #(.ADDR_W(ADDR_W), .WIN_BITS(MEM_WIN_BITS)) u_mem_cmp (
        .tag_i  (addr_i[ADDR_W-1 -: MEM_TAG_W]),
        .base_i (memmap_cfg_i[MEM_TAG_W-1:0]),
        .en_i   (1'b1),
        .hit_o  (mem_hit)
    );

    always_comb begin
        reg_sel_o  = reg_hit;
        mem_sel_o  = mem_hit && !reg_hit;
        core_rst_o = memmap_cfg_i[MM_POL_BIT] ? rst_pin_i : !rst_pin_i;
    end

    mmap_lo_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .as_i  (as_i),
        .lo_i  (addr_i[BYTE_W-1:0]),
        .lat_o (lat_byte)
    );

    mmap_portb_mux u_pbmux (
        .lam_i      (memmap_cfg_i[MM_LAM_BIT]),
        .lat_i      (lat_byte),
        .gpio_out_i (gpio_out_i),
        .gpio_oe_i  (gpio_oe_i),
        .pb_out_o   (pb_out_o),
        .pb_oe_o    (pb_oe_o)
    );

    assign unused_cfg = ^{memmap_cfg_i[7:6], memmap_cfg_i[4],
                          addr_i[REG_WIN_BITS-1:BYTE_W]};
endmodule

// File: rtl/mmap_chk.sv
module mmap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr_i,
    input logic        as_i,
    input logic        rst_pin_i,
    input logic [7:0]  regmap_cfg_i,
    input logic [7:0]  memmap_cfg_i,
    input logic [7:0]  gpio_out_i,
    input logic [7:0]  gpio_oe_i,
    input logic        reg_sel_o,
    input logic        mem_sel_o,
    input logic        core_rst_o,
    input logic [7:0]  pb_out_o,
    input logic [7:0]  pb_oe_o,
    input logic [7:0]  lat_byte
);
    logic as_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) as_seen <= 1'b0;
        else        as_seen <= as_i;
    end

    AST_REG_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel_o |-> (addr_i[15:10] == regmap_cfg_i[5:0])); // R1
    AST_REG_SEL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (regmap_cfg_i[7:6] != 2'b10) |-> !reg_sel_o); // R2
    AST_MEM_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_o |-> (addr_i[15:13] == memmap_cfg_i[2:0])); // R3
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_sel_o, mem_sel_o}) <= 1); // R4
    AST_RST_ACTIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pin_i == memmap_cfg_i[3]) |-> core_rst_o); // R5
    AST_PB_GPIO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !memmap_cfg_i[5] |-> (pb_out_o == gpio_out_i && pb_oe_o == gpio_oe_i)); // R6
    AST_PB_LAM_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        memmap_cfg_i[5] |-> (pb_oe_o == 8'hFF && pb_out_o == lat_byte)); // R7
    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (as_seen && !as_i) |=> (lat_byte == $past(addr_i[7:0]))); // R8
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(as_seen && !as_i) |=> $stable(lat_byte)); // R8
endmodule

bind mmap_decoder mmap_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .as_i         (as_i),
    .rst_pin_i    (rst_pin_i),
    .regmap_cfg_i (regmap_cfg_i),
    .memmap_cfg_i (memmap_cfg_i),
    .gpio_out_i   (gpio_out_i),
    .gpio_oe_i    (gpio_oe_i),
    .reg_sel_o    (reg_sel_o),
    .mem_sel_o    (mem_sel_o),
    .core_rst_o   (core_rst_o),
    .pb_out_o     (pb_out_o),
    .pb_oe_o      (pb_oe_o),
    .lat_byte     (lat_byte)
);

// File: tb/tb_mmap_decoder.sv
`timescale 1ns/1ps
module tb_mmap_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        as_s = 1'b0;
    logic        rst_pin = 1'b0;
    logic [7:0]  rm = 8'h81;
    logic [7:0]  mm = 8'h07;
    logic [7:0]  gout = 8'h00;
    logic [7:0]  goe = 8'h00;
    logic        reg_sel, mem_sel, core_rst;
    logic [7:0]  pb_out, pb_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mmap_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .as_i(as_s),
        .rst_pin_i(rst_pin), .regmap_cfg_i(rm), .memmap_cfg_i(mm),
        .gpio_out_i(gout), .gpio_oe_i(goe),
        .reg_sel_o(reg_sel), .mem_sel_o(mem_sel), .core_rst_o(core_rst),
        .pb_out_o(pb_out), .pb_oe_o(pb_oe)
    );

    function automatic logic f_reg(logic [15:0] a, logic [7:0] r);
        return (r[7:6] == 2'b10) && (a[15:10] == r[5:0]);
    endfunction
    function automatic logic f_mem(logic [15:0] a, logic [7:0] r, logic [7:0] m);
        return (a[15:13] == m[2:0]) && !f_reg(a, r);
    endfunction
    function automatic logic f_rst(logic pin, logic [7:0] m);
        return m[3] ? pin : !pin;
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (addr=%h rm=%h mm=%h)",
                     req, act, exp, addr, rm, mm);
        end
    endtask

    task automatic chk_comb(string req, logic [7:0] lat_exp);
        chk({req, " reg_sel"}, {15'd0, reg_sel}, {15'd0, f_reg(addr, rm)});
        chk({req, " mem_sel"}, {15'd0, mem_sel}, {15'd0, f_mem(addr, rm, mm)});
        chk({req, " core_rst"}, {15'd0, core_rst}, {15'd0, f_rst(rst_pin, mm)});
        chk({req, " pb_out"}, {8'd0, pb_out}, {8'd0, mm[5] ? lat_exp : gout});
        chk({req, " pb_oe"}, {8'd0, pb_oe}, {8'd0, mm[5] ? 8'hFF : goe});
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    logic [7:0] lat_model = 8'h00;

    initial begin
        void'($urandom(32'd20240611));
        // R9: latch cleared during reset, seen through latched mode
        mm = 8'h27; addr = 16'h12AB; #1;
        chk("R9 reset lat", {8'd0, pb_out}, 16'h0000);
        chk("R7 reset oe", {8'd0, pb_oe}, 16'h00FF);
        // R1 defaults 0x81 / 0x07: reg window at 0x0400, mem at 0xE000
        mm = 8'h07; addr = 16'h0400; #1;
        chk("R1 default reg", {15'd0, reg_sel}, 16'd1);
        addr = 16'hE123; #1;
        chk("R3 default mem", {15'd0, mem_sel}, 16'd1);
        step(); rst_n = 1'b1; step();

        // R2 invalid signature
        for (int s = 0; s < 4; s++) begin
            rm = {s[1:0], 6'h05}; addr = 16'h1400; #1;
            chk("R2 sig", {15'd0, reg_sel}, {15'd0, s[1:0] == 2'b10});
        end
        // R4 overlap: reg window 0xE000 inside mem window 0xE000-0xFFFF
        rm = 8'hB8; mm = 8'h07; addr = 16'hE3FF; #1;
        chk("R4 overlap reg", {15'd0, reg_sel}, 16'd1);
        chk("R4 overlap mem", {15'd0, mem_sel}, 16'd0);
        addr = 16'hE400; #1;
        chk("R4 beside mem", {15'd0, mem_sel}, 16'd1);
        // R5 polarity
        for (int p = 0; p < 4; p++) begin
            mm = {4'h0, p[1], 3'h0}; rst_pin = p[0]; #1;
            chk("R5 pol", {15'd0, core_rst}, {15'd0, p[0] == p[1]});
        end
        // R6 gpio pass
        mm = 8'h00; gout = 8'h5A; goe = 8'h0F; #1;
        chk("R6 out", {8'd0, pb_out}, 16'h005A);
        chk("R6 oe", {8'd0, pb_oe}, 16'h000F);

        // R8 capture sequence, R7 latched mode
        mm = 8'h20;
        step(); as_s = 1'b1; addr = 16'h3377;
        step(); as_s = 1'b0; addr = 16'h44C3;
        step(); addr = 16'h9911;
        #1; chk("R8 capture", {8'd0, pb_out}, 16'h00C3);
        chk("R7 oe", {8'd0, pb_oe}, 16'h00FF);
        step(); addr = 16'h0066; step();
        chk("R8 hold", {8'd0, pb_out}, 16'h00C3);
        as_s = 1'b1; addr = 16'h00EE; step(); step();
        chk("R8 no capture high", {8'd0, pb_out}, 16'h00C3);
        // R9 mid-run reset
        rst_n = 1'b0; #1;
        chk("R9 clear", {8'd0, pb_out}, 16'h0000);
        step(); rst_n = 1'b1; as_s = 1'b0; step();
        lat_model = 8'h00;

        // R10 reserved memmap bits
        rm = 8'h85; addr = 16'hC000; rst_pin = 1'b0; gout = 8'h3C; goe = 8'hF0;
        mm = 8'h06; #1;
        chk_comb("R10 base", lat_model);
        mm = 8'hD6; #1;
        chk_comb("R10 reserved", lat_model);

        // random mix; model capture one edge after falling strobe
        for (int i = 0; i < 400; i++) begin
            logic as_prev;
            as_prev = as_s;
            addr = 16'($urandom);
            as_s = 1'($urandom);
            rst_pin = 1'($urandom);
            gout = 8'($urandom);
            goe = 8'($urandom);
            rm = ($urandom % 4 == 0) ? 8'($urandom) : {2'b10, 6'($urandom)};
            mm = 8'($urandom);
            if (i % 5 == 0) addr[15:10] = rm[5:0];
            if (i % 7 == 0) addr[15:13] = mm[2:0];
            #1; chk_comb("R1 R3 R4 R5 R6 R7 R10 rand", lat_model);
            if (as_prev && !as_s) lat_model = addr[7:0];
            step();
            chk({"R8 rand ", mm[5] ? "lam" : "io"}, {8'd0, pb_out},
                {8'd0, mm[5] ? lat_model : gout});
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule